// File: doc/BRIEF.md
# Prescaled Interval Timer

This block is a memory-mapped 16-bit up-counting interval timer for a small processor subsystem. Software writes a start value, picks a count rate from the base clock divided by 1, 4, 16 or 64, and sets a gate bit. The counter then climbs one step per divided period. When it passes 0xFFFF it raises a status flag, and that flag drives the interrupt line until software writes a zero to it.

An auto-initialize bit selects between two overflow behaviours. In periodic mode the counter reloads the start value and keeps going. In one-shot mode the counter lands on zero and hardware clears the gate bit. Any write of the start value also loads the live counter. A small state machine follows the gate and mode bits through three states. HALT means the gate is off. RUN means the gate is on in interval mode. HOLD means the gate is on while the reserved mode value is set. The named transitions are START (HALT to RUN), PARK (HALT or RUN to HOLD), RESUME (HOLD to RUN) and STOP (RUN or HOLD to HALT). The block has no shared state, so two copies can sit side by side, sixteen bytes apart.

Top module: `itmr_top`

## Requirements
- R1: After reset, all four registers read zero and irq is low.
- R2: A write to the start-value register (word index 0, byte offset 0x0) stores the value and loads the same value into the count register (word index 1) at the same clock edge.
- R3: The count register is read-only. A write to word index 1 leaves the count unchanged.
- R4: The command register (word index 3) holds the clock select in bits [1:0], the mode bit in bit 3, the auto-initialize bit in bit 4 and the gate bit in bit 7. It reads back exactly those bits, with all other bits zero.
- R5: With the gate at 1 and the mode at 0, the count rises by one every D cycles, where D is 1, 4, 16 or 64 for select values 00, 01, 10 and 11. The first increment lands on the (D+1)th rising edge after the edge that wrote the gate bit.
- R6: With the gate at 0, the count holds its value.
- R7: With the mode bit at 1 (reserved), the count holds its value even when the gate is 1.
- R8: An increment from 0xFFFF sets status bit 0, and irq follows that bit.
- R9: With auto-initialize at 1, an overflow loads the start value into the count, and counting continues.
- R10: With auto-initialize at 0, an overflow sets the count to 0x0000 and clears the gate bit, and the count then stays at zero.
- R11: The status flag and irq stay high until software writes status (word index 2) with bit 0 at 0. Writing bit 0 at 1 has no effect.
- R12: When an overflow and a clearing status write fall on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_word | input | 2 | Word index, which is byte-offset bits [3:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the selected register |
| irq | output | 1 | Interrupt, equal to the status flag |

## Verification
The hardest situation to reach from the ports is an overflow that lands on the same edge as a software clear of the flag. The bench sets it up on purpose. It loads 0xFFFF at divide-by-1, works out the overflow edge from the start-edge arithmetic, and issues the clearing write on exactly that edge. Random runs then use start values just below the wrap point, so overflows, reloads and one-shot stops happen often within a few hundred cycles at every divider setting.

// File: rtl/itmr_pkg.sv
`timescale 1ns/1ps
package itmr_pkg;

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } run_state_t;

    // word indices within one timer's window
    localparam logic [1:0] IDX_INIT = 2'd0;
    localparam logic [1:0] IDX_CNT  = 2'd1;
    localparam logic [1:0] IDX_STAT = 2'd2;
    localparam logic [1:0] IDX_CMD  = 2'd3;

    // command register field positions
    localparam int CMD_SEL_LSB  = 0;
    localparam int CMD_MODE_BIT = 3;
    localparam int CMD_AUTO_BIT = 4;
    localparam int CMD_GATE_BIT = 7;

    localparam int STAT_FLAG_BIT = 0;

endpackage

// File: rtl/itmr_prescale.sv
`timescale 1ns/1ps
module itmr_prescale #(
    parameter int PRE_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        unique case (sel)
            2'd0:    mask = PRE_W'(0);
            2'd1:    mask = PRE_W'(3);
            2'd2:    mask = PRE_W'(15);
            default: mask = PRE_W'(63);
        endcase
    end

    // the divider restarts from zero whenever counting is not running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign tick = run && ((pre_q & mask) == mask);

endmodule

// File: rtl/itmr_ctrl_fsm.sv
`timescale 1ns/1ps
module itmr_ctrl_fsm
    import itmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    input  logic mode,
    output logic run
);

    run_state_t state_q;
    run_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: begin
                if (gate && !mode)      state_d = ST_RUN;   // START
                else if (gate && mode)  state_d = ST_HOLD;  // PARK
            end
            ST_RUN: begin
                if (!gate)              state_d = ST_HALT;  // STOP
                else if (mode)          state_d = ST_HOLD;  // PARK
            end
            ST_HOLD: begin
                if (!gate)              state_d = ST_HALT;  // STOP
                else if (!mode)         state_d = ST_RUN;   // RESUME
            end
            default:                    state_d = ST_HALT;
        endcase
    end

    always_comb begin
        run = (state_q == ST_RUN) && gate && !mode;
    end

endmodule

// File: rtl/itmr_counter.sv
`timescale 1ns/1ps
module itmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             autoinit,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);

    logic [CNT_W-1:0] cnt_q;
    logic             at_top;

    assign at_top = &cnt_q;
    assign ovf    = tick && at_top && !load;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick) begin
            if (at_top) begin
                cnt_q <= autoinit ? reload_val : '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/itmr_regs.sv
`timescale 1ns/1ps
module itmr_regs
    import itmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ovf,
    input  logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  init_val,
    output logic              init_wr,
    output logic              clr_wr,
    output logic              gate,
    output logic              mode,
    output logic              autoinit,
    output logic [1:0]        sel,
    output logic              flag
);

    logic [CNT_W-1:0] init_q;
    logic             gate_q;
    logic             mode_q;
    logic             auto_q;
    logic [1:0]       sel_q;
    logic             flag_q;
    logic             cmd_wr;
    logic             stat_wr;
    logic             unused_wdata;

    assign unused_wdata = ^wdata;

    assign init_wr = wr_en && (idx == IDX_INIT);
    assign cmd_wr  = wr_en && (idx == IDX_CMD);
    assign stat_wr = wr_en && (idx == IDX_STAT);
    assign clr_wr  = stat_wr && !wdata[STAT_FLAG_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q <= '0;
        end else if (init_wr) begin
            init_q <= wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
            mode_q <= 1'b0;
            auto_q <= 1'b0;
            sel_q  <= 2'b00;
        end else begin
            if (cmd_wr) begin
                gate_q <= wdata[CMD_GATE_BIT];
                mode_q <= wdata[CMD_MODE_BIT];
                auto_q <= wdata[CMD_AUTO_BIT];
                sel_q  <= wdata[CMD_SEL_LSB +: 2];
            end
            // one-shot: hardware drops the gate after the wrap
            if (ovf && !auto_q) begin
                gate_q <= 1'b0;
            end
        end
    end

    // set beats clear on the same edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (ovf) begin
            flag_q <= 1'b1;
        end else if (clr_wr) begin
            flag_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (idx)
            IDX_INIT: rdata = DATA_W'(init_q);
            IDX_CNT:  rdata = DATA_W'(count);
            IDX_STAT: rdata[STAT_FLAG_BIT] = flag_q;
            default: begin
                rdata[CMD_SEL_LSB +: 2] = sel_q;
                rdata[CMD_MODE_BIT]     = mode_q;
                rdata[CMD_AUTO_BIT]     = auto_q;
                rdata[CMD_GATE_BIT]     = gate_q;
            end
        endcase
    end

    assign init_val = init_q;
    assign gate     = gate_q;
    assign mode     = mode_q;
    assign autoinit = auto_q;
    assign sel      = sel_q;
    assign flag     = flag_q;

endmodule

// File: rtl/itmr_top.sv
`timescale 1ns/1ps
module itmr_top #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int PRE_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [1:0]        bus_word,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    logic              wr_en;
    logic [DATA_W-1:0] reg_rdata;
    logic [CNT_W-1:0]  init_val;
    logic [CNT_W-1:0]  count;
    logic              init_wr;
    logic              clr_wr;
    logic              gate;
    logic              mode;
    logic              autoinit;
    logic [1:0]        sel;
    logic              flag;
    logic              run;
    logic              tick;
    logic              ovf;

    assign wr_en = bus_sel && bus_we;

    itmr_regs #(
        .DATA_W(DATA_W),
        .CNT_W (CNT_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .idx     (bus_word),
        .wdata   (bus_wdata),
        .ovf     (ovf),
        .count   (count),
        .rdata   (reg_rdata),
        .init_val(init_val),
        .init_wr (init_wr),
        .clr_wr  (clr_wr),
        .gate    (gate),
        .mode    (mode),
        .autoinit(autoinit),
        .sel     (sel),
        .flag    (flag)
    );

    itmr_ctrl_fsm u_fsm (
        .clk  (clk),
        .rst_n(rst_n),
        .gate (gate),
        .mode (mode),
        .run  (run)
    );

    itmr_prescale #(
        .PRE_W(PRE_W)
    ) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .sel  (sel),
        .tick (tick)
    );

    itmr_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (init_wr),
        .load_val  (bus_wdata[CNT_W-1:0]),
        .tick      (tick),
        .autoinit  (autoinit),
        .reload_val(init_val),
        .count     (count),
        .ovf       (ovf)
    );

    assign bus_rdata = bus_sel ? reg_rdata : '0;
    assign irq       = flag;

endmodule

// File: rtl/itmr_checker.sv
`timescale 1ns/1ps
module itmr_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ovf,
    input logic             irq,
    input logic             gate,
    input logic             autoinit,
    input logic             run,
    input logic             init_wr,
    input logic             clr_wr,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] init_val,
    input logic [CNT_W-1:0] load_val
);

    // R8
    ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> irq);

    // R10
    oneshot_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !autoinit) |=> !gate);

    // R9
    reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && autoinit) |=> (count == $past(init_val)));

    // R2
    init_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_wr |=> (count == $past(load_val)));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !init_wr) |=> $stable(count));

    // R11
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_wr) |=> irq);

endmodule

bind itmr_top itmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ovf     (ovf),
    .irq     (irq),
    .gate    (gate),
    .autoinit(autoinit),
    .run     (run),
    .init_wr (init_wr),
    .clr_wr  (clr_wr),
    .count   (count),
    .init_val(init_val),
    .load_val(bus_wdata[CNT_W-1:0])
);

// File: tb/itmr_top_bench.sv
`timescale 1ns/1ps
module itmr_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_word = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    itmr_top u_itmr_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_word (bus_word),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq      (irq)
    );

    localparam logic [1:0] W_INIT = 2'd0, W_CNT = 2'd1, W_STAT = 2'd2, W_CMD = 2'd3;
    localparam logic [31:0] GATE = 32'h80, AUTO = 32'h10, MODE = 32'h08;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called and returns at a falling edge; consumes one rising edge
    task automatic wr(input logic [1:0] w, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_word = w; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] w, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_word = w;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int div_of(input logic [1:0] s);
        return 1 << (2 * s);
    endfunction

    function automatic int incs(input int e, input int d);
        return (e >= 1) ? (e - 1) / d : 0;
    endfunction

    function automatic logic [15:0] exp_cnt(input logic [15:0] init, input int n, input bit au);
        int span;
        span = 32'h10000 - int'(init);
        if (n < span) return 16'(int'(init) + n);
        if (au) return 16'(int'(init) + ((n - span) % span));
        return 16'h0000;
    endfunction

    function automatic bit exp_flag(input logic [15:0] init, input int n);
        return n >= (32'h10000 - int'(init));
    endfunction

    task automatic quiesce();
        wr(W_CMD, 32'h0);
        wr(W_STAT, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        void'($urandom(32'h5eed1234));
        edges(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        for (int i = 0; i < 4; i++) begin
            rd(2'(i), v);
            chk("R1 reg after reset", v, 32'h0);
        end
        chk("R1 irq after reset", {31'h0, irq}, 32'h0);

        // R2 start value loads count
        wr(W_INIT, 32'h0000_1234);
        rd(W_INIT, v); chk("R2 start value", v, 32'h1234);
        rd(W_CNT, v);  chk("R2 count loaded", v, 32'h1234);

        // R3 count is read-only
        wr(W_CNT, 32'h0000_AAAA);
        rd(W_CNT, v);  chk("R3 count write ignored", v, 32'h1234);

        // R4 command fields read back; other bits dropped
        wr(W_CMD, 32'hFFFF_FF73);
        rd(W_CMD, v);  chk("R4 command readback", v, 32'h13);
        // R6 gate off: count unchanged
        edges(10);
        rd(W_CNT, v);  chk("R6 count held with gate off", v, 32'h1234);

        // R5 divide-by-4 first increment timing
        quiesce();
        wr(W_INIT, 32'h0100);
        wr(W_CMD, GATE | 32'h1);
        edges(4);
        rd(W_CNT, v);  chk("R5 no increment before D+1 edges", v, 32'h0100);
        edges(1);
        rd(W_CNT, v);  chk("R5 first increment at D+1", v, 32'h0101);
        edges(8);
        rd(W_CNT, v);  chk("R5 rate one per D cycles", v, 32'h0103);

        // R6 stop then hold
        wr(W_CMD, 32'h1);
        rd(W_CNT, v);
        chk("R6 count at stop edge", v, 32'(16'h0100 + incs(14, 4)));
        edges(20);
        rd(W_CNT, v2); chk("R6 count held after stop", v2, v);

        // R7 reserved mode holds the count
        wr(W_INIT, 32'h0200);
        wr(W_CMD, GATE | MODE);
        edges(30);
        rd(W_CNT, v);  chk("R7 mode 1 no counting", v, 32'h0200);

        // R8 / R10 one-shot overflow at divide-by-1
        quiesce();
        wr(W_INIT, 32'hFFFE);
        wr(W_CMD, GATE);
        edges(2);
        rd(W_CNT, v);  chk("R8 count before wrap", v, 32'hFFFF);
        chk("R8 irq low before wrap", {31'h0, irq}, 32'h0);
        edges(1);
        rd(W_CNT, v);  chk("R10 one-shot wraps to zero", v, 32'h0);
        chk("R8 irq after wrap", {31'h0, irq}, 32'h1);
        rd(W_STAT, v); chk("R8 status flag", v, 32'h1);
        rd(W_CMD, v);  chk("R10 gate cleared by hardware", v, 32'h0);
        edges(10);
        rd(W_CNT, v);  chk("R10 count stays zero", v, 32'h0);

        // R11 flag holds until a zero is written
        wr(W_STAT, 32'h1);
        chk("R11 writing one keeps irq", {31'h0, irq}, 32'h1);
        edges(5);
        chk("R11 irq still held", {31'h0, irq}, 32'h1);
        wr(W_STAT, 32'h0);
        chk("R11 irq cleared", {31'h0, irq}, 32'h0);
        rd(W_STAT, v); chk("R11 status cleared", v, 32'h0);

        // R9 periodic reload
        wr(W_INIT, 32'hFFFD);
        wr(W_CMD, GATE | AUTO);
        edges(5);
        rd(W_CNT, v);  chk("R9 reload then continue", v, 32'hFFFE);
        chk("R9 irq on periodic wrap", {31'h0, irq}, 32'h1);
        rd(W_CMD, v);  chk("R9 gate kept", v, GATE | AUTO);

        // R12 overflow and clear on the same edge
        quiesce();
        wr(W_INIT, 32'hFFFF);
        wr(W_CMD, GATE);
        edges(1);
        wr(W_STAT, 32'h0);
        chk("R12 set wins over clear", {31'h0, irq}, 32'h1);
        rd(W_CNT, v);  chk("R12 count wrapped", v, 32'h0);

        // random runs near the wrap point
        for (int it = 0; it < 40; it++) begin
            logic [1:0]  s;
            bit          au;
            int          d, w, n;
            logic [15:0] init;
            s    = 2'($urandom_range(0, 3));
            au   = 1'($urandom_range(0, 1));
            d    = div_of(s);
            w    = $urandom_range(0, 200);
            init = 16'(32'hFFFF - $urandom_range(0, 200 / d));
            quiesce();
            wr(W_INIT, {16'h0, init});
            wr(W_CMD, GATE | (au ? AUTO : 32'h0) | 32'(s));
            edges(w);
            n = incs(w, d);
            rd(W_CNT, v);
            chk(au ? "R9 random periodic count" : "R5 random count", v, {16'h0, exp_cnt(init, n, au)});
            chk("R8 random irq", {31'h0, irq}, {31'h0, exp_flag(init, n)});
            if (!au) begin
                rd(W_CMD, v);
                chk("R10 random gate", v, (exp_flag(init, n) ? 32'h0 : GATE) | 32'(s));
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule